// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between a set of transmit mailboxes and the CAN bit engine. Each mailbox is loaded by a one-cycle request strobe that carries an 11-bit identifier. The scheduler keeps the mailbox pending and offers one pending mailbox at a time to the bit engine. The bit engine reports how each attempt ended, and the scheduler then retires the mailbox or keeps it for another attempt.

Two run-time selects shape the behaviour. The ordering select chooses between identifier order, where the message with the highest bus priority goes first, and arrival order, where the first requested goes first. The single-shot select retires a mailbox after exactly one attempt, whatever the result of that attempt. Each mailbox reports whether it is pending, whether it has completed, and whether its last completion was a successful transmission.

Top module: `can_tx_mbox_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pending_o`, `done_o`, `txok_o` and `sel_valid_o` are all zero.
- R2: A request strobe on a mailbox that is not pending captures its identifier and sets its pending bit at the next clock edge. At the same edge the mailbox's `done_o` and `txok_o` bits clear. A mailbox is never pending and done at the same time.
- R3: With `order_mode_i` = 0, the pending mailbox with the numerically lowest identifier is selected. When identifiers are equal, the lowest mailbox index wins.
- R4: With `order_mode_i` = 1, pending mailboxes are selected in the order their requests arrived. Mailboxes requested in the same cycle are ordered by lowest index.
- R5: The scheduler chooses only while `sel_valid_o` is low. When any mailbox is pending, `sel_valid_o` rises one cycle later and `sel_idx_o` names the chosen mailbox. Both then hold until an outcome strobe arrives. `sel_valid_o` is low for the cycle after an outcome, and the choice is then made again.
- R6: A success outcome (`tx_ok_i`) retires the selected mailbox at the next edge, with `done_o` = 1 and `txok_o` = 1. If several outcome strobes are high in the same cycle, success takes precedence.
- R7: With `single_shot_i` = 0, an error (`tx_err_i`) or a lost arbitration (`arb_lost_i`) leaves the selected mailbox pending with its identifier unchanged and its arrival position kept.
- R8: With `single_shot_i` = 1, an error or a lost arbitration retires the selected mailbox at the next edge, with `done_o` = 1 and `txok_o` = 0.
- R9: A request strobe on a mailbox that is already pending is ignored. Its identifier and its arrival position stay unchanged.
- R10: Outcome strobes are ignored while `sel_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Per-mailbox request strobe, one cycle |
| id_i | input | 33 | Identifiers, mailbox k at bits [11k+10:11k] |
| order_mode_i | input | 1 | 0: identifier order, 1: arrival order |
| single_shot_i | input | 1 | 1: one attempt per request |
| tx_ok_i | input | 1 | Attempt finished successfully |
| tx_err_i | input | 1 | Attempt finished with an error |
| arb_lost_i | input | 1 | Attempt lost arbitration |
| sel_valid_o | output | 1 | A mailbox is offered to the bit engine |
| sel_idx_o | output | 2 | Index of the offered mailbox |
| pending_o | output | 3 | Per-mailbox pending flag |
| done_o | output | 3 | Per-mailbox completed flag |
| txok_o | output | 3 | Per-mailbox successful-completion flag |

## Verification
The ordering logic is tested in both modes with three kinds of identifier pattern. Ascending-but-shuffled identifiers show whether the minimum search ranks the right mailbox. Equal identifiers show whether ties go to the lowest index. Arrival sequences that run against identifier order can only pass if the arrival record, and not the identifier, drives the choice. Repeated error and lost-arbitration outcomes, with and without single-shot, separate retry from retirement. A retried mailbox must keep its place ahead of later arrivals. A re-strobe carrying a much smaller identifier while the mailbox is pending, and an outcome pulse before any selection, both confirm that those inputs leave the state untouched.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int unsigned CAN_ID_W = 11;

  typedef enum logic [1:0] {
    OUTC_NONE = 2'd0,
    OUTC_OK   = 2'd1,
    OUTC_FAIL = 2'd2
  } outcome_e;
endpackage

// File: rtl/can_txmb_pick.sv
module can_txmb_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned KW = 11,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand_i,
  input  logic [KW-1:0] key_i [N],
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [KW-1:0] best_key;

  // strict less-than keeps the lowest index on equal keys
  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    best_key = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (cand_i[i] && (!found_o || (key_i[i] < best_key))) begin
        found_o  = 1'b1;
        idx_o    = IW'(i);
        best_key = key_i[i];
      end
    end
  end
endmodule

// File: rtl/can_txmb_rank.sv
module can_txmb_rank #(
  parameter int unsigned N = 3,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned RW = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  arrive_i,
  input  logic          retire_en_i,
  input  logic [IW-1:0] retire_idx_i,
  output logic [RW-1:0] rank_o [N]
);
  logic [RW-1:0] rank_q [N];
  logic [RW-1:0] rank_d [N];
  logic [CW-1:0] keep_cnt;
  logic [RW-1:0] ret_rank;
  logic          upd_en;

  // number of mailboxes still waiting after this edge's retirement
  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (pend_i[i] && !(retire_en_i && (retire_idx_i == IW'(i))))
        keep_cnt = keep_cnt + CW'(1);
    end
  end

  always_comb begin
    ret_rank = '0;
    for (int i = 0; i < int'(N); i++)
      if (retire_idx_i == IW'(i)) ret_rank = rank_q[i];
  end

  assign upd_en = retire_en_i || (|arrive_i);

  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      rank_d[i] = rank_q[i];
      if (arrive_i[i])
        rank_d[i] = RW'(keep_cnt);
      else if (retire_en_i && pend_i[i] && (rank_q[i] > ret_rank))
        rank_d[i] = rank_q[i] - RW'(1);
    end
  end

  generate
    for (genvar g = 0; g < int'(N); g++) begin : g_rank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rank_q[g] <= '0;
        else if (upd_en) rank_q[g] <= rank_d[g];
      end
      assign rank_o[g] = rank_q[g];

      // R4: a waiting mailbox never has more predecessors than other mailboxes exist
      p_rank_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i[g] |-> (int'(rank_q[g]) < int'(N)));
    end
  endgenerate
endmodule

// File: rtl/can_tx_mbox_sched.sv
module can_tx_mbox_sched #(
  parameter int unsigned NUM_MB = 3,
  localparam int unsigned IDW = can_txmb_pkg::CAN_ID_W,
  localparam int unsigned IW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int unsigned RW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_MB-1:0]     req_i,
  input  logic [NUM_MB*IDW-1:0] id_i,
  input  logic                  order_mode_i,
  input  logic                  single_shot_i,
  input  logic                  tx_ok_i,
  input  logic                  tx_err_i,
  input  logic                  arb_lost_i,
  output logic                  sel_valid_o,
  output logic [IW-1:0]         sel_idx_o,
  output logic [NUM_MB-1:0]     pending_o,
  output logic [NUM_MB-1:0]     done_o,
  output logic [NUM_MB-1:0]     txok_o
);
  import can_txmb_pkg::*;

  logic [NUM_MB-1:0] pend_q, pend_d;
  logic [NUM_MB-1:0] done_q, done_d;
  logic [NUM_MB-1:0] ok_q, ok_d;
  logic [IDW-1:0]    id_q [NUM_MB];
  logic [NUM_MB-1:0] arrive;
  logic [RW-1:0]     rank [NUM_MB];
  logic [IDW-1:0]    key [NUM_MB];
  logic              sel_v_q, sel_v_d;
  logic [IW-1:0]     sel_idx_q, sel_idx_d;
  logic              pick_found;
  logic [IW-1:0]     pick_idx;
  outcome_e          outc;
  logic              retire_en;
  logic              retire_ok;

  // outcome decode: only meaningful while a mailbox is offered
  always_comb begin
    outc = OUTC_NONE;
    if (sel_v_q) begin
      if (tx_ok_i)                    outc = OUTC_OK;
      else if (tx_err_i || arb_lost_i) outc = OUTC_FAIL;
    end
  end

  assign retire_ok = (outc == OUTC_OK);
  assign retire_en = retire_ok || ((outc == OUTC_FAIL) && single_shot_i);
  assign arrive    = req_i & ~pend_q;

  // per-mailbox status next state
  always_comb begin
    pend_d = pend_q;
    done_d = done_q;
    ok_d   = ok_q;
    for (int i = 0; i < int'(NUM_MB); i++) begin
      if (arrive[i]) begin
        pend_d[i] = 1'b1;
        done_d[i] = 1'b0;
        ok_d[i]   = 1'b0;
      end else if (retire_en && (sel_idx_q == IW'(i))) begin
        pend_d[i] = 1'b0;
        done_d[i] = 1'b1;
        ok_d[i]   = retire_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
      ok_q   <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  generate
    for (genvar g = 0; g < int'(NUM_MB); g++) begin : g_mb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         id_q[g] <= '0;
        else if (arrive[g]) id_q[g] <= id_i[g*IDW +: IDW];
      end

      assign key[g] = order_mode_i ? {{(IDW-RW){1'b0}}, rank[g]} : id_q[g];

      // R9: a strobe on a waiting mailbox leaves its identifier alone
      p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[g] && pend_q[g]) |=> $stable(id_q[g]));

      // R2: pending and completed are exclusive
      p_pend_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending_o[g] && done_o[g]));
    end
  endgenerate

  can_txmb_rank #(.N(NUM_MB)) u_rank (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (pend_q),
    .arrive_i     (arrive),
    .retire_en_i  (retire_en),
    .retire_idx_i (sel_idx_q),
    .rank_o       (rank)
  );

  can_txmb_pick #(.N(NUM_MB), .KW(IDW)) u_pick (
    .cand_i  (pend_q),
    .key_i   (key),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  // selection: chosen while idle, frozen until an outcome
  always_comb begin
    sel_v_d   = sel_v_q;
    sel_idx_d = sel_idx_q;
    if (sel_v_q) begin
      if (outc != OUTC_NONE) sel_v_d = 1'b0;
    end else if (pick_found) begin
      sel_v_d   = 1'b1;
      sel_idx_d = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_v_q   <= 1'b0;
      sel_idx_q <= '0;
    end else begin
      sel_v_q   <= sel_v_d;
      sel_idx_q <= sel_idx_d;
    end
  end

  assign sel_valid_o = sel_v_q;
  assign sel_idx_o   = sel_idx_q;
  assign pending_o   = pend_q;
  assign done_o      = done_q;
  assign txok_o      = ok_q;

  // R5: offer held while no outcome is reported
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && !tx_ok_i && !tx_err_i && !arb_lost_i) |=> (sel_valid_o && $stable(sel_idx_o)));

  // R5: the offered mailbox is always a pending one
  p_sel_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> pending_o[sel_idx_o]);

  // R5: after an outcome the offer drops for one cycle
  p_sel_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && (tx_ok_i || tx_err_i || arb_lost_i)) |=> !sel_valid_o);

  // R6: success retires with the OK flag
  p_ok_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && tx_ok_i) |=>
      (done_o[$past(sel_idx_o)] && txok_o[$past(sel_idx_o)] && !pending_o[$past(sel_idx_o)]));

  // R7: failed attempt in retry mode keeps the mailbox
  p_retry_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && !tx_ok_i && (tx_err_i || arb_lost_i) && !single_shot_i) |=>
      pending_o[$past(sel_idx_o)]);

  // R8: failed single-shot attempt retires without the OK flag
  p_single_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && !tx_ok_i && (tx_err_i || arb_lost_i) && single_shot_i) |=>
      (done_o[$past(sel_idx_o)] && !txok_o[$past(sel_idx_o)] && !pending_o[$past(sel_idx_o)]));

  // R10: outcome strobes without an offer change no status
  p_idle_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_valid_o && req_i == '0) |=> ($stable(done_o) && $stable(txok_o)));
endmodule

// File: tb/can_tx_mbox_sched_tb.sv
module can_tx_mbox_sched_tb;
  localparam int N   = 3;
  localparam int IDW = 11;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   req;
  logic [N*IDW-1:0] ids;
  logic           order_mode, single_shot, tx_ok, tx_err, arb_lost;
  logic           sel_valid;
  logic [1:0]     sel_idx;
  logic [N-1:0]   pending, done, txok;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  can_tx_mbox_sched #(.NUM_MB(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .id_i(ids),
    .order_mode_i(order_mode), .single_shot_i(single_shot),
    .tx_ok_i(tx_ok), .tx_err_i(tx_err), .arb_lost_i(arb_lost),
    .sel_valid_o(sel_valid), .sel_idx_o(sel_idx),
    .pending_o(pending), .done_o(done), .txok_o(txok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit m_pend[N], m_done[N], m_ok[N];
  int m_id[N], m_stamp[N];
  int m_seq;
  bit m_sv;
  int m_si;

  function automatic int ref_pick();
    int best = -1;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i]) begin
        if (best < 0) best = i;
        else if (order_mode ? (m_stamp[i] < m_stamp[best]) : (m_id[i] < m_id[best])) best = i;
      end
    end
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pend[i] = 0; m_done[i] = 0; m_ok[i] = 0; m_id[i] = 0; m_stamp[i] = 0;
      end
      m_seq = 0; m_sv = 0; m_si = 0;
    end else begin
      bit was_pend[N];
      bit any_new;
      int w;
      for (int i = 0; i < N; i++) was_pend[i] = m_pend[i];
      w = ref_pick();
      if (m_sv) begin
        if (tx_ok) begin
          m_pend[m_si] = 0; m_done[m_si] = 1; m_ok[m_si] = 1; m_sv = 0;
        end else if (tx_err || arb_lost) begin
          if (single_shot) begin
            m_pend[m_si] = 0; m_done[m_si] = 1; m_ok[m_si] = 0;
          end
          m_sv = 0;
        end
      end else if (w >= 0) begin
        m_sv = 1; m_si = w;
      end
      any_new = 0;
      for (int i = 0; i < N; i++) begin
        if (req[i] && !was_pend[i]) begin
          m_pend[i] = 1; m_done[i] = 0; m_ok[i] = 0;
          m_id[i] = int'(ids[i*IDW +: IDW]); m_stamp[i] = m_seq; any_new = 1;
        end
      end
      if (any_new) m_seq++;
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int mvec(input bit v[N]);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r |= (1 << i);
    return r;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(sel_valid == m_sv, "R5 sel_valid", int'(sel_valid), int'(m_sv));
      if (m_sv) check(int'(sel_idx) == m_si, "R3 R4 sel_idx", int'(sel_idx), m_si);
      check(int'(pending) == mvec(m_pend), "R2 pending", int'(pending), mvec(m_pend));
      check(int'(done) == mvec(m_done), "R6 R8 done", int'(done), mvec(m_done));
      check(int'(txok) == mvec(m_ok), "R6 R8 txok", int'(txok), mvec(m_ok));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_req(input logic [N-1:0] m, input int i0, input int i1, input int i2);
    @(negedge clk);
    req = m;
    ids = {IDW'(i2), IDW'(i1), IDW'(i0)};
    @(negedge clk);
    req = '0;
  endtask

  task automatic expect_sel(input int idx, input string tag);
    int t = 0;
    while (!sel_valid && t < 50) begin @(negedge clk); t++; end
    check(sel_valid && int'(sel_idx) == idx, tag, int'(sel_idx), idx);
  endtask

  // kind: 0 success, 1 error, 2 arbitration lost
  task automatic outcome(input int kind);
    @(negedge clk);
    tx_ok = (kind == 0); tx_err = (kind == 1); arb_lost = (kind == 2);
    @(negedge clk);
    tx_ok = 0; tx_err = 0; arb_lost = 0;
  endtask

  initial begin
    while (cycles < 20000) @(negedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; req = '0; ids = '0; order_mode = 0; single_shot = 0;
    tx_ok = 0; tx_err = 0; arb_lost = 0;
    repeat (3) @(negedge clk);
    check(pending == 0 && done == 0 && txok == 0 && !sel_valid, "R1 reset", int'(pending), 0);
    rst_n = 1;
    @(negedge clk);
    check(pending == 0 && done == 0 && txok == 0 && !sel_valid, "R1 after reset", int'(done), 0);

    // R3: identifier order, shuffled identifiers
    do_req(3'b111, 'h300, 'h100, 'h200);
    check(pending == 3'b111, "R2 pending set", int'(pending), 7);
    expect_sel(1, "R3 lowest id first");
    outcome(0);
    expect_sel(2, "R3 second id");
    outcome(0);
    expect_sel(0, "R3 third id");
    outcome(0);
    @(negedge clk);
    check(done == 3'b111 && txok == 3'b111, "R6 all succeeded", int'(txok), 7);

    // R3: equal identifiers resolved by lowest index
    do_req(3'b110, 'h0AA, 'h0AA, 'h0AA);
    check(done == 3'b001, "R2 done cleared on request", int'(done), 1);
    expect_sel(1, "R3 tie lowest index");
    outcome(0);
    expect_sel(2, "R3 tie second");
    outcome(0);

    // R4: arrival order against identifier order
    order_mode = 1;
    do_req(3'b100, 0, 0, 'h7FF);
    do_req(3'b001, 'h400, 0, 0);
    do_req(3'b010, 0, 'h000, 0);
    expect_sel(2, "R4 first arrival");
    outcome(0);
    expect_sel(0, "R4 second arrival");
    outcome(0);
    expect_sel(1, "R4 third arrival");
    outcome(0);

    // R4: simultaneous arrivals ordered by index
    do_req(3'b101, 'h700, 0, 'h001);
    expect_sel(0, "R4 simultaneous lowest index");
    outcome(0);
    expect_sel(2, "R4 simultaneous next");
    outcome(0);

    // R7: retry keeps arrival position
    do_req(3'b001, 'h600, 0, 0);
    do_req(3'b010, 0, 'h001, 0);
    expect_sel(0, "R7 oldest chosen");
    outcome(1);
    @(negedge clk);
    check(pending == 3'b011 && done[0] == 0, "R7 kept after error", int'(pending), 3);
    expect_sel(0, "R7 retried first after error");
    outcome(2);
    expect_sel(0, "R7 retried first after lost arbitration");
    outcome(0);
    expect_sel(1, "R7 later arrival afterwards");
    outcome(0);

    // R8: single shot
    order_mode = 0; single_shot = 1;
    do_req(3'b100, 0, 0, 'h010);
    expect_sel(2, "R8 offered");
    outcome(2);
    @(negedge clk);
    check(done[2] && !txok[2] && !pending[2], "R8 retired on lost arbitration", int'(done), 4);
    do_req(3'b001, 'h020, 0, 0);
    expect_sel(0, "R8 offered second");
    outcome(1);
    @(negedge clk);
    check(done[0] && !txok[0] && !pending[0], "R8 retired on error", int'(txok), 0);
    do_req(3'b010, 0, 'h030, 0);
    expect_sel(1, "R8 offered third");
    outcome(0);
    @(negedge clk);
    check(done[1] && txok[1], "R6 single-shot success", int'(txok), 2);

    // R9: strobe on pending mailbox ignored
    single_shot = 0;
    do_req(3'b011, 'h500, 'h100, 0);
    expect_sel(1, "R9 setup");
    do_req(3'b001, 'h010, 0, 0);
    do_req(3'b100, 0, 0, 'h050);
    outcome(0);
    expect_sel(2, "R9 old identifier kept");
    outcome(0);
    expect_sel(0, "R9 last");
    outcome(0);

    // R10: outcome before an offer ignored
    @(negedge clk);
    req = 3'b010; ids = {IDW'(0), IDW'('h111), IDW'(0)};
    @(negedge clk);
    req = '0; tx_ok = 1;
    @(negedge clk);
    tx_ok = 0;
    check(pending[1] && !done[1] && sel_valid, "R10 idle outcome ignored", int'(pending), 2);
    outcome(0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule